// File: doc/BRIEF.md
# Interrupt Pending and Log Controller

This block is the interrupt subsystem of a serial avionics bus terminal core. Single-cycle event strobes from the rest of the core enter on two buses. The hardware bus carries four sources. The message bus carries twelve. Each strobe is gated by a host-written enable mask and then sets a bit in a pending register. The host reads the pending register and clears bits by writing ones. The host interrupt line stays high while any pending bit that is also enabled in the mask is set.

Hardware-class events use the top four pending bits. They never touch memory. Once any of them is pending, further hardware events are ignored until the host clears it. Message-class events also produce a two-word record in a 32-word circular log, written through a memory write port while logging is enabled. The first word identifies the cause. The second word is an address or information value supplied with the event. Records that collide with a write in progress wait in a one-deep holding slot, so none is dropped. The log address comes from a pointer register. Its low five bits step once per word written, and its upper bits hold the ring base.

Top module: `irq_log_ctrl`

## Requirements
- R1: An event strobe sets its pending bit only if the matching mask bit is 1. A masked-off event leaves the pending register unchanged and produces no log record.
- R2: Pending bits 15..12 are the hardware class, fed by `evt_hw[3:0]`. Bits 11..0 are the message class, fed by `evt_msg[11:0]`. A hardware event never causes a memory write.
- R3: While any of pending bits 15..12 is set, new hardware events set no pending bit. After the host clears them, a new hardware event sets its bit again.
- R4: A host write to the pending register clears every bit written as 1 and leaves the other bits alone.
- R5: `host_irq` is 1 exactly when (pending AND mask) is nonzero. Clearing a mask bit therefore drops the line without changing the pending register.
- R6: A logged message event writes its identification word at the pointer address in the cycle after the strobe. It writes the information word at the next ring address in the following cycle. The identification word holds the accepted message bits in bits 11..0 and zeros in bits 15..12. The information word is `evt_info` from the strobe cycle.
- R7: Each log word written advances pointer bits 4..0 by one, wrapping from 31 to 0. Pointer bits 15..5 stay fixed. With the offset starting at 0, the 17th record lands at offset 0 again.
- R8: Message events accepted in the same cycle form one record whose identification word is the OR of their bits.
- R9: A record that arrives while a write is in progress waits in a one-deep holding slot and is written next. If the slot is already full, the new record merges into it: the identification bits are ORed and the newer information word is kept.
- R10: With `log_en` low, message events still set pending bits but produce no memory write, and the pointer does not move.
- R11: Reset clears mask, pending and pointer. `host_irq` and `mem_we` are then 0.
- R12: Register address 0 is the mask, 1 is the pending register and 2 is the pointer. Address 0 and 2 take host writes directly, and every register reads back on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 pending, 2 pointer |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| log_en | input | 1 | Enables log records for message events |
| evt_hw | input | 4 | Hardware-class event strobes (pending bits 15..12) |
| evt_msg | input | 12 | Message-class event strobes (pending bits 11..0) |
| evt_info | input | 16 | Information word accompanying message strobes |
| mem_we | output | 1 | Log memory write enable |
| mem_addr | output | 16 | Log memory word address (pointer value) |
| mem_wdata | output | 16 | Log memory write data |
| host_irq | output | 1 | Host interrupt request |

## Verification
Logging and event acceptance overlap. A new message strobe can arrive while the writer is still emitting an earlier two-word record. The bench provokes this with strobes on four consecutive cycles. The second strobe lands in the holding slot, and the fourth strobe arrives while that slot is still full, so it must merge. A scoreboard queue holds the predicted address and data of every log word. Each memory write is judged against the head of the queue, so a lost, duplicated or reordered record shows up as a mismatch or as an unexpected write.

// File: rtl/irq_log_pkg.sv
// Package: shared constants and types for the interrupt pending/log controller.
// Assumes a 16-bit register and log word width throughout.
package irq_log_pkg;

    localparam int DATA_W = 16;

    // One pending log record: identification word plus information word.
    typedef struct packed {
        logic [DATA_W-1:0] id;
        logic [DATA_W-1:0] info;
    } log_rec_t;

    // Log writer phase: idle, emitting the id word, emitting the info word.
    typedef enum logic [1:0] {
        LW_IDLE = 2'd0,
        LW_ID   = 2'd1,
        LW_INFO = 2'd2
    } lw_state_t;

endpackage

// File: rtl/irq_pend_unit.sv
// Module: mask and pending registers with hardware-class lockout and the
// host interrupt output.
// Assumes the top HW_N bits of the pending register are the hardware class,
// strobes last one cycle, and a host clear never cancels a set in the same cycle.
module irq_pend_unit
    import irq_log_pkg::*;
#(
    parameter int HW_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mask_we,
    input  logic                   pend_clr_we,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [HW_N-1:0]        evt_hw,
    input  logic [DATA_W-HW_N-1:0] evt_msg,
    output logic [DATA_W-1:0]      mask_q,
    output logic [DATA_W-1:0]      pend_q,
    output logic [DATA_W-HW_N-1:0] msg_hit,
    output logic                   host_irq
);

    localparam int MSG_N = DATA_W - HW_N;

    logic [HW_N-1:0]   hw_hit;
    logic              hw_locked;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    // Gate strobes by the mask and apply the hardware lockout.
    always_comb begin
        hw_hit    = evt_hw & mask_q[DATA_W-1 -: HW_N];
        hw_locked = |pend_q[DATA_W-1 -: HW_N];
        msg_hit   = evt_msg & mask_q[MSG_N-1:0];
        set_vec   = {(hw_locked ? {HW_N{1'b0}} : hw_hit), msg_hit};
        clr_vec   = pend_clr_we ? wdata : '0;
    end

    // Mask register: plain host write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Pending register: write-one-to-clear, new sets take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // Interrupt line follows any enabled pending bit.
    assign host_irq = |(pend_q & mask_q);

endmodule

// File: rtl/irq_log_writer.sv
// Module: two-word log writer with a one-deep holding slot and the ring
// pointer register.
// Assumes one incoming record per cycle at most. A record that arrives while
// the slot is occupied is merged into it. A host pointer write overrides the
// increment in that cycle.
module irq_log_writer
    import irq_log_pkg::*;
#(
    parameter int RING_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  log_rec_t          rec_in,
    input  logic              ptr_we,
    input  logic [DATA_W-1:0] ptr_wdata,
    output logic [DATA_W-1:0] ptr_q,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              word1
);

    lw_state_t state;
    log_rec_t  cur;
    log_rec_t  hold;
    logic      hold_v;
    logic      free;

    // The engine can accept a record when idle or on its last word.
    assign free = (state == LW_IDLE) || (state == LW_INFO);

    // Pointer: host write wins, otherwise the ring offset steps per word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_we)
            ptr_q <= ptr_wdata;
        else if (state != LW_IDLE)
            ptr_q <= {ptr_q[DATA_W-1:RING_AW], ptr_q[RING_AW-1:0] + 1'b1};
    end

    // Record sequencing between the holding slot and the active record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LW_IDLE;
            cur    <= '0;
            hold   <= '0;
            hold_v <= 1'b0;
        end else if (free) begin
            if (hold_v) begin
                cur    <= hold;
                state  <= LW_ID;
                hold_v <= rec_valid;
                if (rec_valid) hold <= rec_in;
            end else if (rec_valid) begin
                cur   <= rec_in;
                state <= LW_ID;
            end else begin
                state <= LW_IDLE;
            end
        end else begin
            state <= LW_INFO;
            if (rec_valid) begin
                hold_v <= 1'b1;
                hold   <= hold_v ? '{id: hold.id | rec_in.id, info: rec_in.info}
                                 : rec_in;
            end
        end
    end

    // Memory port driven straight from the writer state.
    assign mem_we    = (state != LW_IDLE);
    assign mem_addr  = ptr_q;
    assign mem_wdata = (state == LW_ID) ? cur.id : cur.info;
    assign word1     = (state == LW_INFO);

endmodule

// File: rtl/irq_log_ctrl.sv
// Module: top of the interrupt pending and log controller. Decodes the host
// register port, forms log records from accepted message events and joins
// the pending unit to the log writer.
// Assumes reg_rdata is sampled combinationally and evt_info is valid with
// any message strobe.
module irq_log_ctrl
    import irq_log_pkg::*;
#(
    parameter int HW_N    = 4,
    parameter int RING_AW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   log_en,
    input  logic [HW_N-1:0]        evt_hw,
    input  logic [DATA_W-HW_N-1:0] evt_msg,
    input  logic [DATA_W-1:0]      evt_info,
    output logic                   mem_we,
    output logic [DATA_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic                   host_irq
);

    localparam int MSG_N = DATA_W - HW_N;

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] ptr_q;
    logic [MSG_N-1:0]  msg_hit;
    logic              log_word1;
    logic              rec_valid;
    log_rec_t          rec_in;

    // Form a log record from the accepted message bits.
    always_comb begin
        rec_valid = log_en && (|msg_hit);
        rec_in    = '{id: {{HW_N{1'b0}}, msg_hit}, info: evt_info};
    end

    // Host read multiplexer.
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = mask_q;
            2'd1:    reg_rdata = pend_q;
            2'd2:    reg_rdata = ptr_q;
            default: reg_rdata = '0;
        endcase
    end

    irq_pend_unit #(.HW_N(HW_N)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_we     (reg_wr && (reg_addr == 2'd0)),
        .pend_clr_we (reg_wr && (reg_addr == 2'd1)),
        .wdata       (reg_wdata),
        .evt_hw      (evt_hw),
        .evt_msg     (evt_msg),
        .mask_q      (mask_q),
        .pend_q      (pend_q),
        .msg_hit     (msg_hit),
        .host_irq    (host_irq)
    );

    irq_log_writer #(.RING_AW(RING_AW)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_in    (rec_in),
        .ptr_we    (reg_wr && (reg_addr == 2'd2)),
        .ptr_wdata (reg_wdata),
        .ptr_q     (ptr_q),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .word1     (log_word1)
    );

endmodule

// File: rtl/irq_log_ctrl_chk.sv
// Checker: temporal properties of the interrupt pending and log controller,
// attached to the top through bind.
module irq_log_ctrl_chk #(
    parameter int HW_N    = 4,
    parameter int RING_AW = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] mask_q,
    input logic [15:0] pend_q,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        log_word1
);

    // R1
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == 16'h0));

    // R3
    hw_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q[15 -: HW_N]) |=>
            ((pend_q[15 -: HW_N] & ~$past(pend_q[15 -: HW_N])) == '0));

    // R6
    id_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !log_word1) |-> (mem_wdata != 16'h0 && mem_wdata[15 -: HW_N] == '0));

    // R7
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !log_word1 && !(reg_wr && reg_addr == 2'd2)) |=>
            (mem_we && log_word1 &&
             mem_addr[15:RING_AW] == $past(mem_addr[15:RING_AW]) &&
             mem_addr[RING_AW-1:0] == $past(mem_addr[RING_AW-1:0]) + 1'b1));

endmodule

bind irq_log_ctrl irq_log_ctrl_chk #(.HW_N(HW_N), .RING_AW(RING_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .log_word1 (log_word1)
);

// File: tb/irq_log_ctrl_test.sv
`timescale 1ns/1ps
// Bench: scoreboard of predicted log writes plus register read checks.
module irq_log_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        log_en = 1'b0;
    logic [3:0]  evt_hw = 4'h0;
    logic [11:0] evt_msg = 12'h0;
    logic [15:0] evt_info = 16'h0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    irq_log_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .log_en(log_en),
        .evt_hw(evt_hw), .evt_msg(evt_msg), .evt_info(evt_info),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .host_irq(host_irq)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata == e, tag, {16'h0, reg_rdata}, {16'h0, e});
    endtask

    task automatic pulse(input logic [3:0] hw, input logic [11:0] msg, input logic [15:0] info);
        evt_hw = hw; evt_msg = msg; evt_info = info;
        @(negedge clk);
        evt_hw = 4'h0; evt_msg = 12'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every log write must match the head of the prediction queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected log write", {mem_addr, mem_wdata}, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R6/R7 log word", {mem_addr, mem_wdata}, e);
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        check(1'b0, "watchdog R6", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R11 reset state
        rd_chk(2'd0, 16'h0000, "R11 mask");
        rd_chk(2'd1, 16'h0000, "R11 pending");
        rd_chk(2'd2, 16'h0000, "R11 pointer");
        check(host_irq == 1'b0 && mem_we == 1'b0, "R11 outputs", {host_irq, mem_we}, 0);

        // R1 masked events ignored
        log_en = 1'b1;
        pulse(4'b0001, 12'h001, 16'h1234);
        idle(3);
        rd_chk(2'd1, 16'h0000, "R1 masked pending");
        check(host_irq == 1'b0, "R1 masked irq", host_irq, 0);

        wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'h0100);
        rd_chk(2'd0, 16'hFFFF, "R12 mask readback");
        rd_chk(2'd2, 16'h0100, "R12 pointer readback");

        // R6 single record, R5 irq, R4 clear
        expect_wr(16'h0100, 16'h0001);
        expect_wr(16'h0101, 16'hA5A5);
        pulse(4'h0, 12'h001, 16'hA5A5);
        idle(3);
        rd_chk(2'd1, 16'h0001, "R6 pending set");
        check(host_irq == 1'b1, "R5 irq high", host_irq, 1);
        wr(2'd1, 16'h0001);
        rd_chk(2'd1, 16'h0000, "R4 W1C clear");
        check(host_irq == 1'b0, "R4 irq low after clear", host_irq, 0);

        // R8 same-cycle merge
        expect_wr(16'h0102, 16'h0006);
        expect_wr(16'h0103, 16'h1111);
        pulse(4'h0, 12'h006, 16'h1111);
        idle(3);
        wr(2'd1, 16'h0002);
        rd_chk(2'd1, 16'h0004, "R4 partial clear");
        wr(2'd1, 16'hFFFF);

        // R9 back-to-back: hold slot and merge into full slot
        expect_wr(16'h0104, 16'h0001); expect_wr(16'h0105, 16'h0A01);
        expect_wr(16'h0106, 16'h0002); expect_wr(16'h0107, 16'h0A02);
        expect_wr(16'h0108, 16'h000C); expect_wr(16'h0109, 16'h0A04);
        evt_msg = 12'h001; evt_info = 16'h0A01; @(negedge clk);
        evt_msg = 12'h002; evt_info = 16'h0A02; @(negedge clk);
        evt_msg = 12'h004; evt_info = 16'h0A03; @(negedge clk);
        evt_msg = 12'h008; evt_info = 16'h0A04; @(negedge clk);
        evt_msg = 12'h000;
        idle(10);
        rd_chk(2'd1, 16'h000F, "R9 pending all");
        check(exp_q.size() == 0, "R9 all records written", exp_q.size(), 0);
        wr(2'd1, 16'hFFFF);

        // R7 wrap from offset 31 to 0
        wr(2'd2, 16'h021E);
        expect_wr(16'h021E, 16'h0010); expect_wr(16'h021F, 16'h7777);
        expect_wr(16'h0200, 16'h0020); expect_wr(16'h0201, 16'h5555);
        pulse(4'h0, 12'h010, 16'h7777);
        idle(3);
        pulse(4'h0, 12'h020, 16'h5555);
        idle(3);
        rd_chk(2'd2, 16'h0202, "R7 pointer after wrap");
        wr(2'd1, 16'hFFFF);

        // R7 seventeen records: the 17th returns to offset 0
        wr(2'd2, 16'h0300);
        for (int k = 0; k < 17; k++) begin
            expect_wr(16'h0300 | 16'((2*k) % 32), 16'(1 << (k % 12)));
            expect_wr(16'h0300 | 16'((2*k+1) % 32), 16'(k + 16'h0100));
            pulse(4'h0, 12'(1 << (k % 12)), 16'(k + 16'h0100));
            idle(2);
        end
        idle(3);
        rd_chk(2'd2, 16'h0302, "R7 pointer after 17 records");
        wr(2'd1, 16'hFFFF);

        // R10 logging disabled
        log_en = 1'b0;
        pulse(4'h0, 12'h080, 16'hBEEF);
        idle(3);
        rd_chk(2'd1, 16'h0080, "R10 pending still set");
        rd_chk(2'd2, 16'h0302, "R10 pointer unchanged");
        wr(2'd1, 16'hFFFF);
        log_en = 1'b1;

        // R2 / R3 hardware class and lockout
        pulse(4'b0001, 12'h000, 16'h0);
        idle(2);
        rd_chk(2'd1, 16'h1000, "R2 hardware bit 12");
        check(host_irq == 1'b1, "R2 hardware irq", host_irq, 1);
        pulse(4'b0010, 12'h000, 16'h0);
        idle(2);
        rd_chk(2'd1, 16'h1000, "R3 second hardware locked out");
        wr(2'd1, 16'h1000);
        pulse(4'b0010, 12'h000, 16'h0);
        idle(2);
        rd_chk(2'd1, 16'h2000, "R3 accepted after clear");
        wr(2'd1, 16'hFFFF);

        // R5 mask drops irq without touching pending
        expect_wr(16'h0302, 16'h0001); expect_wr(16'h0303, 16'hC0DE);
        pulse(4'h0, 12'h001, 16'hC0DE);
        idle(3);
        check(host_irq == 1'b1, "R5 irq with pending", host_irq, 1);
        wr(2'd0, 16'hFFFE);
        #1;
        check(host_irq == 1'b0, "R5 irq masked off", host_irq, 0);
        rd_chk(2'd1, 16'h0001, "R5 pending kept");
        rd_chk(2'd0, 16'hFFFE, "R12 mask readback 2");

        idle(5);
        check(exp_q.size() == 0, "R6 no missing log words", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule